// File: doc/BRIEF.md
# Fixed-Point Fused Multiply-Add (Linear Interpolator)

This block evaluates y = m*x + b on signed fixed-point operands. Each of the four values has its own integer width and fractional width, fixed at elaboration. The integer width counts the sign bit and may be zero or negative, as long as the total word length stays positive. The block derives the intermediate formats from the operand formats. The product m*x is formed at full width. The intercept b is then aligned to the product's binary point and added with one bit of integer growth, so that neither step loses information.

The exact sum is converted to y's format in one final stage, and only there. Surplus fractional bits are discarded toward minus infinity, and missing fractional bits are filled with zeros. A sum outside y's range is either saturated to the nearest rail or wrapped, depending on a parameter. In both cases a clipping flag reports the overflow.

A second parameter selects one of two output modes:
- A registered stage with a synchronous reset and a valid pair.
- A purely combinational path, in which out_valid simply mirrors in_valid.

Top module: `fxp_lerp`

## Requirements
- R1: When the exact value m*x + b fits in y's format, y equals that value rounded toward minus infinity to Y_QW fractional bits. No rounding happens before the add. For example, a product of minus one product-LSB plus b = 0 gives y = all ones (minus one y-LSB).
- R2: When Y_QW exceeds the fractional width of the sum, y carries the exact sum with zero low-order bits appended.
- R3: With SATURATE = 1, a result above y's maximum gives y = 0 followed by all ones. A result below y's minimum gives y = 1 followed by all zeros. In both cases clipping = 1.
- R4: With SATURATE = 0, an out-of-range result gives y equal to the low Y_W bits of the floored result in two's complement, and clipping = 1.
- R5: clipping is 0 whenever the floored result is within y's range.
- R6: With OUT_REG = 1, y, clipping and out_valid take the values for the inputs sampled at a rising edge where in_valid = 1, and they show those values after that edge. out_valid after each edge equals in_valid before it.
- R7: With OUT_REG = 1, the synchronous active-high rst clears out_valid, y and clipping to 0 at the next rising edge.
- R8: Negative integer widths are valid operand formats. For example, an m in format s(-1).9 is computed correctly.
- R9: With OUT_REG = 1 and in_valid = 0 at an edge, y and clipping keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies m, x and b |
| m | input | M_IW+M_QW | Slope, two's complement |
| x | input | X_IW+X_QW | Abscissa, two's complement |
| b | input | B_IW+B_QW | Intercept, two's complement |
| y | output | Y_IW+Y_QW | Result in y's format |
| clipping | output | 1 | Result exceeded y's range |
| out_valid | output | 1 | Qualifies y and clipping |

## Verification
The properties assume that rst is sampled synchronously and that in_valid is a clean level at each rising edge. The rail property also assumes saturation mode, where every clipped output must lie on a rail. The stimulus drives all inputs half a cycle away from the sampling edge. It draws operands as raw bit patterns over their whole two's-complement range, so rails, wrap and floor cases all arise. Directed operands force both rails, an exact in-range value and a tiny negative product. A second instance checks the wrap mode, zero padding of fractional bits and a negative integer width without a register.

// File: rtl/fxp_lerp_pkg.sv
package fxp_lerp_pkg;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fxp_mul.sv
// Full-precision signed product: no bits are discarded.
module fxp_mul #(
  parameter int A_W = 16,
  parameter int B_W = 16
) (
  input  logic signed [A_W-1:0]     a,
  input  logic signed [B_W-1:0]     b,
  output logic signed [A_W+B_W-1:0] p
);
  localparam int P_W = A_W + B_W;

  logic signed [P_W-1:0] a_ext, b_ext;

  assign a_ext = P_W'(a);
  assign b_ext = P_W'(b);
  assign p     = a_ext * b_ext;
endmodule

// File: rtl/fxp_align_add.sv
// Aligns two signed operands to a shared fractional width and adds exactly.
module fxp_align_add #(
  parameter int P_W  = 32,
  parameter int P_QW = 26,
  parameter int B_W  = 16,
  parameter int B_QW = 10,
  parameter int S_W  = 33,
  parameter int S_QW = 26
) (
  input  logic signed [P_W-1:0] p,
  input  logic signed [B_W-1:0] b,
  output logic signed [S_W-1:0] s
);
  localparam int P_SH = S_QW - P_QW;
  localparam int B_SH = S_QW - B_QW;

  logic signed [S_W-1:0] p_al, b_al;

  assign p_al = S_W'(p) <<< P_SH;
  assign b_al = S_W'(b) <<< B_SH;
  assign s    = p_al + b_al;
endmodule

// File: rtl/fxp_resize.sv
// Single output conversion: floor or zero-pad the fraction, then wrap or saturate.
module fxp_resize #(
  parameter int I_W      = 33,
  parameter int I_QW     = 26,
  parameter int O_IW     = 5,
  parameter int O_QW     = 11,
  parameter bit SATURATE = 1'b1
) (
  input  logic signed [I_W-1:0]       din,
  output logic        [O_IW+O_QW-1:0] dout,
  output logic                        clip
);
  localparam int O_W  = O_IW + O_QW;
  localparam int PAD  = (O_QW > I_QW) ? (O_QW - I_QW) : 0;
  localparam int DROP = (I_QW > O_QW) ? (I_QW - O_QW) : 0;
  localparam int T_W  = I_W + PAD;

  logic signed [T_W-1:0] t;

  // Arithmetic right shift discards LSBs toward minus infinity.
  assign t = (T_W'(din) <<< PAD) >>> DROP;

  generate
    if (T_W <= O_W) begin : g_fits
      assign dout = O_W'(t);
      assign clip = 1'b0;
    end else begin : g_narrow
      localparam logic signed [T_W-1:0] HI = {{(T_W-O_W+1){1'b0}}, {(O_W-1){1'b1}}};
      localparam logic signed [T_W-1:0] LO = {{(T_W-O_W+1){1'b1}}, {(O_W-1){1'b0}}};
      logic over, under;
      assign over  = (t > HI);
      assign under = (t < LO);
      assign clip  = over | under;
      if (SATURATE) begin : g_sat
        assign dout = over  ? HI[O_W-1:0] :
                      under ? LO[O_W-1:0] : t[O_W-1:0];
      end else begin : g_wrap
        assign dout = t[O_W-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/fxp_lerp.sv
module fxp_lerp
  import fxp_lerp_pkg::*;
#(
  parameter int M_IW     = 2,
  parameter int M_QW     = 14,
  parameter int X_IW     = 4,
  parameter int X_QW     = 12,
  parameter int B_IW     = 6,
  parameter int B_QW     = 10,
  parameter int Y_IW     = 5,
  parameter int Y_QW     = 11,
  parameter bit SATURATE = 1'b1,
  parameter bit OUT_REG  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [M_IW+M_QW-1:0] m,
  input  logic [X_IW+X_QW-1:0] x,
  input  logic [B_IW+B_QW-1:0] b,
  output logic [Y_IW+Y_QW-1:0] y,
  output logic                 clipping,
  output logic                 out_valid
);
  localparam int M_W  = M_IW + M_QW;
  localparam int X_W  = X_IW + X_QW;
  localparam int B_W  = B_IW + B_QW;
  localparam int Y_W  = Y_IW + Y_QW;
  localparam int P_IW = M_IW + X_IW;
  localparam int P_QW = M_QW + X_QW;
  localparam int P_W  = M_W + X_W;
  localparam int S_IW = imax(P_IW, B_IW) + 1;
  localparam int S_QW = imax(P_QW, B_QW);
  localparam int S_W  = S_IW + S_QW;

  logic signed [P_W-1:0] prod;
  logic signed [S_W-1:0] sum;
  logic [Y_W-1:0]        y_c;
  logic                  clip_c;

  fxp_mul #(.A_W(M_W), .B_W(X_W)) u_mul (
    .a ($signed(m)),
    .b ($signed(x)),
    .p (prod)
  );

  fxp_align_add #(
    .P_W(P_W), .P_QW(P_QW), .B_W(B_W), .B_QW(B_QW), .S_W(S_W), .S_QW(S_QW)
  ) u_add (
    .p (prod),
    .b ($signed(b)),
    .s (sum)
  );

  fxp_resize #(
    .I_W(S_W), .I_QW(S_QW), .O_IW(Y_IW), .O_QW(Y_QW), .SATURATE(SATURATE)
  ) u_rsz (
    .din  (sum),
    .dout (y_c),
    .clip (clip_c)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid <= 1'b0;
          y         <= '0;
          clipping  <= 1'b0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            y        <= y_c;
            clipping <= clip_c;
          end
        end
      end
    end else begin : g_comb
      assign y         = y_c;
      assign clipping  = clip_c;
      assign out_valid = in_valid;
    end
  endgenerate
endmodule

// File: rtl/fxp_lerp_chk.sv
module fxp_lerp_chk #(
  parameter int Y_W      = 16,
  parameter bit SATURATE = 1'b1,
  parameter bit OUT_REG  = 1'b1
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [Y_W-1:0] y,
  input logic           clipping,
  input logic           out_valid
);
  localparam logic [Y_W-1:0] Y_HI = {1'b0, {(Y_W-1){1'b1}}};
  localparam logic [Y_W-1:0] Y_LO = {1'b1, {(Y_W-1){1'b0}}};

  generate
    if (OUT_REG) begin : g_reg_props
      // R6
      p_valid_rise_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid)
        else $error("out_valid missing one cycle after in_valid");
      // R6
      p_valid_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid)
        else $error("out_valid set without in_valid");
      // R9
      p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(y) && $stable(clipping)))
        else $error("output changed while idle");
      // R7
      p_reset_r7: assert property (@(posedge clk)
        rst |=> (!out_valid && !clipping && (y == '0)))
        else $error("reset did not clear outputs");
      if (SATURATE) begin : g_sat_props
        // R3
        p_rail_r3: assert property (@(posedge clk) disable iff (rst)
          clipping |-> ((y == Y_HI) || (y == Y_LO)))
          else $error("clipped output not on a rail");
      end
    end
  endgenerate
endmodule

bind fxp_lerp fxp_lerp_chk #(
  .Y_W(Y_IW + Y_QW), .SATURATE(SATURATE), .OUT_REG(OUT_REG)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .y         (y),
  .clipping  (clipping),
  .out_valid (out_valid)
);

// File: tb/fxp_lerp_test.sv
`timescale 1ns/1ps
module fxp_lerp_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [15:0] m = '0, x = '0, b = '0;
  logic [15:0] y;
  logic clipping, out_valid;
  logic [7:0]  m2 = '0, x2 = '0;
  logic [13:0] b2 = '0;
  logic [15:0] y2;
  logic clip2, vld2;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  // Default: m s2.14, x s4.12, b s6.10, y s5.11, saturate, registered.
  fxp_lerp uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .m(m), .x(x), .b(b),
    .y(y), .clipping(clipping), .out_valid(out_valid)
  );

  // m s(-1).9, x s3.5, b s2.12, y s1.15, wrap, combinational.
  fxp_lerp #(
    .M_IW(-1), .M_QW(9), .X_IW(3), .X_QW(5), .B_IW(2), .B_QW(12),
    .Y_IW(1), .Y_QW(15), .SATURATE(1'b0), .OUT_REG(1'b0)
  ) uut2 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .m(m2), .x(x2), .b(b2),
    .y(y2), .clipping(clip2), .out_valid(vld2)
  );

  function automatic longint sext(input longint v, input int w);
    return (v <<< (64 - w)) >>> (64 - w);
  endfunction

  function automatic longint model(input longint mv, input longint xv, input longint bv,
                                   input int mqw, input int xqw, input int bqw,
                                   input int yiw, input int yqw, input bit sat,
                                   output bit clip);
    int pqw, sqw, yw;
    longint s, r, hi, lo;
    pqw = mqw + xqw;
    sqw = (pqw > bqw) ? pqw : bqw;
    s   = ((mv * xv) <<< (sqw - pqw)) + (bv <<< (sqw - bqw));
    r   = (yqw >= sqw) ? (s <<< (yqw - sqw)) : (s >>> (sqw - yqw));
    yw  = yiw + yqw;
    hi  = (64'sd1 <<< (yw - 1)) - 1;
    lo  = -hi - 1;
    clip = (r > hi) || (r < lo);
    if (!clip) return r;
    if (sat) return (r > hi) ? hi : lo;
    return sext(r, yw);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] mm, input logic [15:0] xx, input logic [15:0] bb,
                       input logic [7:0] mm2, input logic [7:0] xx2, input logic [13:0] bb2);
    longint e1, e2;
    bit c1, c2;
    e1 = model(sext(longint'(mm), 16), sext(longint'(xx), 16), sext(longint'(bb), 16),
               14, 12, 10, 5, 11, 1'b1, c1);
    e2 = model(sext(longint'(mm2), 8), sext(longint'(xx2), 8), sext(longint'(bb2), 14),
               9, 5, 12, 1, 15, 1'b0, c2);
    @(negedge clk);
    m = mm; x = xx; b = bb; m2 = mm2; x2 = xx2; b2 = bb2; in_valid = 1'b1;
    #1;
    chk(c2 ? "R4" : "R2/R8", sext(longint'(y2), 16), e2);
    chk(c2 ? "R4" : "R5", longint'(clip2), longint'(c2));
    @(negedge clk);
    chk(c1 ? "R3" : "R1", sext(longint'(y), 16), e1);
    chk(c1 ? "R3" : "R5", longint'(clipping), longint'(c1));
    chk("R6", longint'(out_valid), 1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] y_keep;
    logic        c_keep;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R7", longint'(y), 0);
    chk("R7", longint'(out_valid), 0);
    chk("R7", longint'(clipping), 0);
    rst = 1'b0;

    // R1: 1.0 * 1.0 + 0 = 1.0 -> 0x0800 in s5.11
    apply(16'h4000, 16'h1000, 16'h0000, 8'h00, 8'h00, 14'h0000);
    // R1: tiny negative product floors to -1 LSB
    apply(16'hFFFF, 16'h0001, 16'h0000, 8'hFF, 8'h01, 14'h0000);
    // R3: upper rail
    apply(16'h7FFF, 16'h7FFF, 16'h7FFF, 8'h7F, 8'h7F, 14'h1FFF);
    // R3: lower rail
    apply(16'h8000, 16'h7FFF, 16'h8000, 8'h80, 8'h7F, 14'h2000);
    // R8: most negative m with most negative x
    apply(16'h8000, 16'h8000, 16'h0000, 8'h80, 8'h80, 14'h0000);

    for (int i = 0; i < 300; i++) begin
      apply(16'($urandom), 16'($urandom), 16'($urandom),
            8'($urandom), 8'($urandom), 14'($urandom));
    end

    // R9: idle cycle with new operands keeps the outputs
    y_keep = y;
    c_keep = clipping;
    @(negedge clk);
    in_valid = 1'b0;
    m = 16'h7FFF; x = 16'h7FFF; b = 16'h1234;
    @(negedge clk);
    chk("R9", longint'(y), longint'(y_keep));
    chk("R9", longint'(clipping), longint'(c_keep));
    chk("R6", longint'(out_valid), 0);

    // R7: reset in mid-run after a clipped result
    apply(16'h7FFF, 16'h7FFF, 16'h7FFF, 8'h00, 8'h00, 14'h0000);
    rst = 1'b1;
    @(negedge clk);
    chk("R7", longint'(y), 0);
    chk("R7", longint'(clipping), 0);
    chk("R7", longint'(out_valid), 0);
    rst = 1'b0;
    in_valid = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule